// File: doc/BRIEF.md
# SPI Register Slave with 3-Wire / 4-Wire Read-Back

This block is a slave serial-port engine that lets an external master read or write one 8-bit register, out of a bank addressed with 7 bits, per chip-select frame. The master pulls the active-low select low, toggles the serial clock from an idle-high level, and sends sixteen bits. The first bit gives the direction, the next seven give the register address, and the last eight carry the data byte. Every field is sent most significant bit first. The slave samples the data line on rising serial-clock edges. It launches read data on falling edges.

All pins are brought into the system clock domain through a synchronizer chain before any edge is detected. The register file sits outside the block. It is reached through a one-cycle read strobe and a one-cycle write strobe that share one address bus, and it returns read data one system clock after the read strobe. A mode input chooses where read data goes. In 4-wire mode it leaves on a dedicated output pin. In 3-wire mode it goes back out on the shared data-in pin. Each output has its own tri-state enable.

Each serial-clock phase, high or low, must last at least SYNC_STAGES + 3 system clocks.

Top module: `spiRegPort`

## Requirements
- R1: After reset, both output enables (`spiDoutOe`, `spiDinOe`) and both strobes (`regRdEn`, `regWrEn`) are low.
- R2: Serial data is sampled on rising edges of `spiClk` while `spiCsN` is low. Frame bit 0 is the direction (1 = read, 0 = write). Bits 1 to 7 are address bits 6 down to 0. Bits 8 to 15 are data bits 7 down to 0.
- R3: A write frame with exactly 16 rising edges produces, after `spiCsN` rises, exactly one single-cycle `regWrEn` pulse. During that pulse `regAddr` holds the frame's address and `regWrData` holds its data byte.
- R4: A write frame with fewer or more than 16 rising edges produces no `regWrEn` pulse, and the addressed register keeps its old value.
- R5: In a read frame, the 8th rising edge produces one single-cycle `regRdEn` pulse with the frame's address on `regAddr`. `regRdData` is captured one system clock after that pulse.
- R6: Read data is sent MSB first. A new bit is launched on each falling edge from the one that opens bit 8 through the one that opens bit 15, and it is stable at the following rising edge.
- R7: Both output enables stay low while `spiCsN` is high, during bits 0 to 7, and for the whole of a write frame.
- R8: With `threeWire` = 1, read data appears on `spiDinOut` with `spiDinOe` high and `spiDoutOe` low. With `threeWire` = 0, it appears on `spiDout` with `spiDoutOe` high and `spiDinOe` low.
- R9: A read frame never produces a `regWrEn` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spiClk | input | 1 | Serial clock from the master, idle high |
| spiCsN | input | 1 | Active-low frame select |
| spiDin | input | 1 | Serial data in (input side of the shared pin) |
| threeWire | input | 1 | 1 = read data returned on the shared data pin |
| spiDout | output | 1 | Serial data out, 4-wire mode |
| spiDoutOe | output | 1 | Tri-state enable for `spiDout` |
| spiDinOut | output | 1 | Output side of the shared data pin, 3-wire mode |
| spiDinOe | output | 1 | Tri-state enable for the shared data pin |
| regAddr | output | 7 | Register address for both strobes |
| regWrData | output | 8 | Write data, valid during `regWrEn` |
| regWrEn | output | 1 | Single-cycle write strobe |
| regRdEn | output | 1 | Single-cycle read strobe |
| regRdData | input | 8 | Read data, valid one clock after `regRdEn` |

## Verification
The bench builds the block with its default parameters: ADDR_W = 7, DATA_W = 8 and SYNC_STAGES = 2, with the serial clock running at five system clocks per phase. With a 7-bit address space, every register can be written and then read back in both pin modes. The expected byte for each address is computed arithmetically from the address, so every address bit position and every data bit position is exercised in both states. At this serial clock rate the margin between the synchronizer delay and each clock phase is small. That exposes any latency error in the launch of read data or in the capture from the register file. Frames of 10, 15 and 17 clocks cover the cut-short and over-long cases.

// File: rtl/spiRegPkg.sv
package spiRegPkg;

  // Per-cycle commands from the frame controller to the datapath
  typedef struct packed {
    logic clearFrame;  // select just went low: start a clean frame
    logic shiftIn;     // rising edge inside the 16-bit window
    logic latchAddr;   // header complete on this rising edge
    logic loadTx;      // capture register read data
    logic shiftOut;    // falling edge in the read-data window
    logic commitWr;    // valid write frame closed by select rising
  } dpStrobe_t;

endpackage

// File: rtl/spiInSync.sv
module spiInSync #(
  parameter int          STAGES  = 2,
  parameter int          WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= RST_VAL;
          else       stageQ[s] <= rawIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= RST_VAL;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/spiFrameCtrl.sv
module spiFrameCtrl
  import spiRegPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       spcS,
  input  logic       csS,
  input  logic       hdrRw,
  output dpStrobe_t  strb,
  output logic       rdEn,
  output logic       wrEn,
  output logic       driveOn
);

  localparam int HDR_LEN   = 1 + ADDR_W;
  localparam int FRAME_LEN = HDR_LEN + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  logic             spcQ;
  logic             csQ;
  logic             rwQ;
  logic             overRun;
  logic             rdPend;
  logic [CNT_W-1:0] bitCnt;

  logic spcRise, spcFall, csRise, csFall;
  logic inDataWin;

  assign spcRise   = spcS & ~spcQ & ~csS;
  assign spcFall   = ~spcS & spcQ & ~csS;
  assign csRise    = csS & ~csQ;
  assign csFall    = ~csS & csQ;
  assign inDataWin = (bitCnt >= CNT_W'(HDR_LEN)) && (bitCnt < CNT_W'(FRAME_LEN));

  always_comb begin
    strb.clearFrame = csFall;
    strb.shiftIn    = spcRise && (bitCnt < CNT_W'(FRAME_LEN));
    strb.latchAddr  = spcRise && (bitCnt == CNT_W'(HDR_LEN - 1));
    strb.loadTx     = rdPend;
    strb.shiftOut   = spcFall && rwQ && inDataWin;
    strb.commitWr   = csRise && !rwQ && !overRun && (bitCnt == CNT_W'(FRAME_LEN));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spcQ    <= 1'b1;
      csQ     <= 1'b1;
      bitCnt  <= '0;
      overRun <= 1'b0;
      driveOn <= 1'b0;
    end else begin
      spcQ <= spcS;
      csQ  <= csS;
      if (csS) begin
        bitCnt  <= '0;
        overRun <= 1'b0;
        driveOn <= 1'b0;
      end else begin
        if (spcRise) begin
          if (bitCnt < CNT_W'(FRAME_LEN)) bitCnt  <= bitCnt + 1'b1;
          else                            overRun <= 1'b1;
        end
        if (strb.shiftOut && (bitCnt == CNT_W'(HDR_LEN))) driveOn <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rwQ    <= 1'b0;
      rdEn   <= 1'b0;
      rdPend <= 1'b0;
      wrEn   <= 1'b0;
    end else begin
      if (strb.latchAddr) rwQ <= hdrRw;
      rdEn   <= strb.latchAddr & hdrRw;
      rdPend <= rdEn;
      wrEn   <= strb.commitWr;
    end
  end

  // R3: the write strobe lasts one cycle and comes only once select is high
  a_r3_wr_single: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);
  a_r3_wr_after_cs: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> csS);
  // R5: the read strobe lasts one cycle
  a_r5_rd_single: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> !rdEn);
  // R7: no driving while select has been high for two cycles
  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    (csS && $past(csS)) |-> !driveOn);
  // R7 / R9: driving only happens in read frames
  a_r7_drive_read_only: assert property (@(posedge clk) disable iff (!rstN)
    driveOn |-> rwQ);

endmodule

// File: rtl/spiFrameDp.sv
module spiFrameDp
  import spiRegPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dinS,
  input  dpStrobe_t         strb,
  output logic              hdrRw,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] regRdData,
  output logic              txBit
);

  localparam int FRAME_LEN = 1 + ADDR_W + DATA_W;

  logic [FRAME_LEN-1:0] rxShift;
  logic [FRAME_LEN-1:0] rxNext;
  logic [DATA_W-1:0]    txReg;

  assign rxNext = {rxShift[FRAME_LEN-2:0], dinS};
  assign hdrRw  = rxNext[ADDR_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      regAddr   <= '0;
      regWrData <= '0;
    end else begin
      if (strb.clearFrame)   rxShift <= '0;
      else if (strb.shiftIn) rxShift <= rxNext;
      if (strb.latchAddr) regAddr   <= rxNext[ADDR_W-1:0];
      if (strb.commitWr)  regWrData <= rxShift[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '0;
      txBit <= 1'b0;
    end else if (strb.clearFrame) begin
      txReg <= '0;
      txBit <= 1'b0;
    end else if (strb.loadTx) begin
      txReg <= regRdData;
    end else if (strb.shiftOut) begin
      txBit <= txReg[DATA_W-1];
      txReg <= {txReg[DATA_W-2:0], 1'b0};
    end
  end

  // R5: register data is captured two cycles after the header completes
  a_r5_load_after_hdr: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadTx |-> $past(strb.latchAddr, 2));
  // R2: shifting in and shifting out never share a cycle
  a_r2_edges_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.shiftIn && strb.shiftOut));

endmodule

// File: rtl/spiRegPort.sv
module spiRegPort
  import spiRegPkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiClk,
  input  logic              spiCsN,
  input  logic              spiDin,
  input  logic              threeWire,
  output logic              spiDout,
  output logic              spiDoutOe,
  output logic              spiDinOut,
  output logic              spiDinOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdEn,
  input  logic [DATA_W-1:0] regRdData
);

  logic [2:0] pinSync;
  logic       spcS, csS, dinS;
  logic       hdrRw, driveOn, txBit;
  dpStrobe_t  strb;

  spiInSync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3),
    .RST_VAL(3'b110)
  ) i_sync (
    .clk    (clk),
    .rstN   (rstN),
    .rawIn  ({spiClk, spiCsN, spiDin}),
    .syncOut(pinSync)
  );

  assign {spcS, csS, dinS} = pinSync;

  spiFrameCtrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .spcS   (spcS),
    .csS    (csS),
    .hdrRw  (hdrRw),
    .strb   (strb),
    .rdEn   (regRdEn),
    .wrEn   (regWrEn),
    .driveOn(driveOn)
  );

  spiFrameDp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .dinS     (dinS),
    .strb     (strb),
    .hdrRw    (hdrRw),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .txBit    (txBit)
  );

  assign spiDout   = txBit;
  assign spiDinOut = txBit;
  assign spiDoutOe = driveOn & ~threeWire;
  assign spiDinOe  = driveOn & threeWire;

  // R8: never more than one output enable at a time
  a_r8_one_driver: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({spiDoutOe, spiDinOe}));
  // R3 / R9: the two strobes never coincide
  a_r9_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));

endmodule

// File: tb/test_spiRegPort.sv
`timescale 1ns/1ps
module test_spiRegPort;

  localparam int HALF = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       spiClk = 1'b1;
  logic       spiCsN = 1'b1;
  logic       spiDin = 1'b0;
  logic       threeWire = 1'b0;
  logic       spiDout, spiDoutOe, spiDinOut, spiDinOe;
  logic [6:0] regAddr;
  logic [7:0] regWrData;
  logic       regWrEn, regRdEn;
  logic [7:0] regRdData = 8'h00;

  logic [7:0] mem [128];
  int wrCount = 0;
  int rdCount = 0;
  logic [6:0] lastWrA;
  logic [7:0] lastWrD;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  spiRegPort i_spiRegPort (
    .clk(clk), .rstN(rstN), .spiClk(spiClk), .spiCsN(spiCsN), .spiDin(spiDin),
    .threeWire(threeWire), .spiDout(spiDout), .spiDoutOe(spiDoutOe),
    .spiDinOut(spiDinOut), .spiDinOe(spiDinOe), .regAddr(regAddr),
    .regWrData(regWrData), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regRdData(regRdData)
  );

  // register file model: one-cycle read latency
  always @(posedge clk) if (regRdEn) regRdData <= mem[regAddr];

  always @(negedge clk) begin
    if (regWrEn) begin
      wrCount++;
      lastWrA = regAddr;
      lastWrD = regWrData;
      mem[regAddr] = regWrData;
    end
    if (regRdEn) rdCount++;
  end

  function automatic logic [7:0] pat(input int a, input int salt);
    return 8'((a * 37 + 11 + salt * 101) & 8'hFF);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one frame; returns the read byte and whether the enables behaved
  task automatic frame(input bit rw, input logic [6:0] a, input logic [7:0] d,
                       input int nClk, output logic [7:0] got,
                       output bit hdrQuiet, output bit dataOeOk);
    logic [15:0] bits;
    bits = {rw, a, d};
    got = 8'h00;
    hdrQuiet = 1'b1;
    dataOeOk = 1'b1;
    spiCsN = 1'b0;
    waitN(HALF);
    for (int i = 0; i < nClk; i++) begin
      spiClk = 1'b0;
      spiDin = (i < 16 && !(rw && i >= 8)) ? bits[15-i] : 1'b0;
      waitN(HALF);
      if (i < 8) begin
        if (spiDoutOe || spiDinOe) hdrQuiet = 1'b0;
      end else if (i < 16) begin
        if (rw) begin
          got[15-i] = threeWire ? spiDinOut : spiDout;
          if (spiDoutOe != !threeWire || spiDinOe != threeWire) dataOeOk = 1'b0;
        end else if (spiDoutOe || spiDinOe) begin
          dataOeOk = 1'b0;
        end
      end
      spiClk = 1'b1;
      waitN(HALF);
    end
    spiCsN = 1'b1;
    waitN(4 * HALF);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] got;
    bit hq, dok;
    int w0, r0;
    for (int k = 0; k < 128; k++) mem[k] = 8'h00;
    waitN(3);
    // R1: reset state
    chk(!spiDoutOe && !spiDinOe, "R1 enables", {spiDoutOe, spiDinOe}, 0);
    chk(!regWrEn && !regRdEn, "R1 strobes", {regWrEn, regRdEn}, 0);
    rstN = 1'b1;
    waitN(5);
    chk(!spiDoutOe && !spiDinOe, "R7 idle enables", {spiDoutOe, spiDinOe}, 0);

    // R2 R3 R7: write every address, 4-wire
    for (int a = 0; a < 128; a++) begin
      w0 = wrCount; r0 = rdCount;
      frame(1'b0, 7'(a), pat(a, 0), 16, got, hq, dok);
      chk(wrCount == w0 + 1, "R3 one write strobe", wrCount - w0, 1);
      chk(lastWrA == 7'(a), "R2 write address", lastWrA, a);
      chk(lastWrD == pat(a, 0), "R2 write data", lastWrD, pat(a, 0));
      chk(hq && dok, "R7 quiet during write", {hq, dok}, 3);
      chk(rdCount == r0, "R3 no read on write", rdCount - r0, 0);
    end

    // R5 R6 R8 R9: read every address, 4-wire
    threeWire = 1'b0;
    for (int a = 0; a < 128; a++) begin
      w0 = wrCount; r0 = rdCount;
      frame(1'b1, 7'(a), 8'h00, 16, got, hq, dok);
      chk(got == pat(a, 0), "R6 read data 4-wire", got, pat(a, 0));
      chk(rdCount == r0 + 1, "R5 one read strobe", rdCount - r0, 1);
      chk(wrCount == w0, "R9 no write on read", wrCount - w0, 0);
      chk(hq, "R7 quiet in header", hq, 1);
      chk(dok, "R8 4-wire enables", dok, 1);
    end

    // R8: read every address, 3-wire
    threeWire = 1'b1;
    for (int a = 0; a < 128; a++) begin
      frame(1'b1, 7'(a), 8'h00, 16, got, hq, dok);
      chk(got == pat(a, 0), "R8 read data 3-wire", got, pat(a, 0));
      chk(hq && dok, "R8 3-wire enables", {hq, dok}, 3);
    end

    // R8: a write in 3-wire mode, then read back
    frame(1'b0, 7'd9, 8'hA5, 16, got, hq, dok);
    frame(1'b1, 7'd9, 8'h00, 16, got, hq, dok);
    chk(got == 8'hA5, "R8 3-wire write readback", got, 8'hA5);
    threeWire = 1'b0;

    // R4: short and long write frames change nothing
    w0 = wrCount;
    frame(1'b0, 7'd5, 8'h3C, 10, got, hq, dok);
    chk(wrCount == w0, "R4 10-clock frame", wrCount - w0, 0);
    frame(1'b0, 7'd5, 8'h3C, 15, got, hq, dok);
    chk(wrCount == w0, "R4 15-clock frame", wrCount - w0, 0);
    frame(1'b0, 7'd5, 8'h3C, 17, got, hq, dok);
    chk(wrCount == w0, "R4 17-clock frame", wrCount - w0, 0);
    frame(1'b1, 7'd5, 8'h00, 16, got, hq, dok);
    chk(got == pat(5, 0), "R4 register kept", got, pat(5, 0));

    // R3: an exact frame right after the bad ones still writes
    w0 = wrCount;
    frame(1'b0, 7'd127, 8'hFF, 16, got, hq, dok);
    chk(wrCount == w0 + 1 && lastWrD == 8'hFF, "R3 recovery write", lastWrD, 8'hFF);
    chk(!spiDoutOe && !spiDinOe, "R7 idle after frames", {spiDoutOe, spiDinOe}, 0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule